// File: doc/BRIEF.md
# Two-Window Overlay Blender

This block merges two pixel streams into one 24-bit RGB stream for a display pipeline. The lower layer (window 0) is the primary background plane. The upper layer (window 1) is a small overlay such as a pointer. It sits above window 0 and may be blended with a constant alpha, blended with an alpha carried in its own pixels, or cut out by a colour key.

Each window has the following configuration:

- an enable bit
- a 4-bit pixel format code
- a top-left position
- a size

Every cycle, the block receives from the timing generator:

- the current screen coordinate
- the data-enable flag
- one 32-bit pixel word from each window

The block then produces the composed pixel two clock cycles later, with data enable delayed to match.

The blender does not fetch memory, handle bursts or unpack formats beyond reordering bytes and widening 5/6-bit fields. It expects a pixel word for every window on every cycle and decides for itself whether that word is used.

Top module: `ovl_blend_top`

## Requirements
- R1: While rst_n is low, out_de and out_rgb are 0.
- R2: out_de equals pix_de delayed by exactly two clock cycles. out_rgb is 0 whenever out_de is 0.
- R3: A window covers every screen coordinate from pos to last inclusive, on each axis. last is pos + size − 1, except that last is 0 when pos + size is 0.
- R4: Format codes 0–3 select these byte placements, with the top byte ignored or lowest byte ignored as shown. Code 0 uses R[23:16] G[15:8] B[7:0]. Code 1 uses B[23:16] G[15:8] R[7:0]. Code 2 uses R[31:24] G[23:16] B[15:8]. Code 3 uses B[31:24] G[23:16] R[15:8]. When only window 0 covers the pixel, its colour passes to the output unchanged, as out_rgb = {R, G, B}.
- R5: For a window 1 pixel in a format without alpha (codes 0–4), each channel blends with the matching byte of const_alpha (R in bits 23:16, G in 15:8, B in 7:0). A value of 0xFF replaces window 0 completely.
- R6: Codes 5–8 carry per-pixel alpha, and any code above 8 behaves as code 8. Code 5 is like code 0 and code 6 like code 1, each with alpha in bits 31:24. Code 7 is like code 2 and code 8 like code 3, each with alpha in bits 7:0. For window 1, this alpha applies to all three channels and const_alpha is not used.
- R7: Each channel is computed as (a·top + (255 − a)·bottom + 127) / 255, rounded down. The bottom value is black wherever window 0 does not cover the pixel.
- R8: When key_en is set and ((window 1 colour XOR key_val) AND key_mask) is zero, that window 1 pixel is transparent. Window 0 is never keyed.
- R9: A window whose enable bit is 0 contributes nothing. Where no window contributes, the output is black while out_de is 1.
- R10: Code 4 is 5-6-5 packed, with R in [15:11], G in [10:5] and B in [4:0]. Each field widens to 8 bits by copying its top bits into the vacated low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | CW | Current screen column |
| pix_y | input | CW | Current screen line |
| pix_de | input | 1 | Active-video flag from the timing generator |
| win_pix | input | 64 | Pixel words; window w in bits [32w+31:32w] |
| win_en | input | 2 | Window enable bits, bit w for window w |
| win_fmt | input | 8 | Format codes, window w in bits [4w+3:4w] |
| win_pos_x | input | 2·CW | Left column of each window |
| win_pos_y | input | 2·CW | Top line of each window |
| win_size_x | input | 2·CW | Width of each window |
| win_size_y | input | 2·CW | Height of each window |
| key_en | input | 1 | Colour key enable for window 1 |
| key_val | input | 24 | Key colour {R,G,B} |
| key_mask | input | 24 | Bits of the key colour that are compared |
| const_alpha | input | 24 | Per-channel constant alpha for window 1 |
| out_de | output | 1 | Delayed active-video flag |
| out_rgb | output | 24 | Composed pixel {R,G,B} |

## Verification
The hardest case to reach from the ports is a colour-key match on window 1. Random 24-bit pixels almost never equal a random key. The bench therefore often builds key_val from the very window 1 pixel it is about to present, after unpacking it by that cycle's format. It also sometimes uses a zero mask, under which every pixel matches. Window placements that are empty, a single pixel wide, or clamped at the origin are reached by directed cases at the exact boundary columns.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NWIN = 2;
  localparam int PIXW = 32;
  localparam int CHW  = 8;
  localparam int FW   = 4;
  localparam int RGBW = 3 * CHW;

  typedef enum logic [FW-1:0] {
    FMT_XRGB   = 4'd0,
    FMT_XBGR   = 4'd1,
    FMT_RGBX   = 4'd2,
    FMT_BGRX   = 4'd3,
    FMT_RGB565 = 4'd4,
    FMT_ARGB   = 4'd5,
    FMT_ABGR   = 4'd6,
    FMT_RGBA   = 4'd7,
    FMT_BGRA   = 4'd8
  } ovl_fmt_e;

  // widen a 5-bit field by repeating its top bits
  function automatic logic [CHW-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CHW-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // {has_alpha, alpha} for a pixel word of the given format
  function automatic logic [CHW:0] pix_alpha(input logic [PIXW-1:0] p,
                                             input logic [FW-1:0] f);
    case (f)
      FMT_XRGB, FMT_XBGR, FMT_RGBX, FMT_BGRX, FMT_RGB565: return '0;
      FMT_ARGB, FMT_ABGR: return {1'b1, p[31:24]};
      default:            return {1'b1, p[7:0]};
    endcase
  endfunction

  // rounded weighted mix of two channel values
  function automatic logic [CHW-1:0] mix8(input logic [CHW-1:0] a,
                                          input logic [CHW-1:0] t,
                                          input logic [CHW-1:0] b);
    logic [16:0] acc;
    logic [CHW-1:0] ia;
    ia  = 8'd255 - a;
    acc = {9'd0, a} * {9'd0, t} + {9'd0, ia} * {9'd0, b} + 17'd127;
    return CHW'(acc / 17'd255);
  endfunction
endpackage

// File: rtl/ovl_win_hit.sv
module ovl_win_hit #(
  parameter int CW = 12
) (
  input  logic          en,
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  output logic          hit
);
  localparam int EW = CW + 1;

  // inclusive last coordinate, held at zero when start plus size is zero
  function automatic logic [EW-1:0] last_of(input logic [CW-1:0] p,
                                            input logic [CW-1:0] s);
    logic [EW-1:0] sum;
    sum = {1'b0, p} + {1'b0, s};
    return (sum == '0) ? '0 : sum - EW'(1);
  endfunction

  logic [EW-1:0] lx, ly;
  logic          in_x, in_y;

  always_comb begin
    lx   = last_of(px, sx);
    ly   = last_of(py, sy);
    in_x = (cx >= px) && ({1'b0, cx} <= lx);
    in_y = (cy >= py) && ({1'b0, cy} <= ly);
    hit  = en && in_x && in_y;
  end
endmodule

// File: rtl/ovl_unpack.sv
module ovl_unpack
  import ovl_pkg::*;
(
  input  logic [PIXW-1:0] pix,
  input  logic [FW-1:0]   fmt,
  output logic [RGBW-1:0] rgb
);
  always_comb begin
    case (fmt)
      FMT_XRGB, FMT_ARGB: rgb = {pix[23:16], pix[15:8], pix[7:0]};
      FMT_XBGR, FMT_ABGR: rgb = {pix[7:0], pix[15:8], pix[23:16]};
      FMT_RGBX, FMT_RGBA: rgb = {pix[31:24], pix[23:16], pix[15:8]};
      FMT_RGB565: rgb = {widen5(pix[15:11]), widen6(pix[10:5]), widen5(pix[4:0])};
      default:            rgb = {pix[15:8], pix[23:16], pix[31:24]};
    endcase
  end
endmodule

// File: rtl/ovl_blend_ch.sv
module ovl_blend_ch
  import ovl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           de,
  input  logic [CHW-1:0] a,
  input  logic [CHW-1:0] t,
  input  logic [CHW-1:0] b,
  output logic [CHW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= de ? mix8(a, t, b) : '0;
  end
endmodule

// File: rtl/ovl_blend_top.sv
module ovl_blend_top
  import ovl_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        pix_x,
  input  logic [CW-1:0]        pix_y,
  input  logic                 pix_de,
  input  logic [NWIN*PIXW-1:0] win_pix,
  input  logic [NWIN-1:0]      win_en,
  input  logic [NWIN*FW-1:0]   win_fmt,
  input  logic [NWIN*CW-1:0]   win_pos_x,
  input  logic [NWIN*CW-1:0]   win_pos_y,
  input  logic [NWIN*CW-1:0]   win_size_x,
  input  logic [NWIN*CW-1:0]   win_size_y,
  input  logic                 key_en,
  input  logic [RGBW-1:0]      key_val,
  input  logic [RGBW-1:0]      key_mask,
  input  logic [RGBW-1:0]      const_alpha,
  output logic                 out_de,
  output logic [RGBW-1:0]      out_rgb
);
  localparam int BOT = 0;
  localparam int TOP = 1;

  logic [NWIN-1:0] in_win;
  logic [RGBW-1:0] win_rgb [NWIN];

  // stage 0: per-window coverage and channel reordering
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    ovl_win_hit #(.CW(CW)) u_hit (
      .en  (win_en[w]),
      .cx  (pix_x),
      .cy  (pix_y),
      .px  (win_pos_x[w*CW +: CW]),
      .py  (win_pos_y[w*CW +: CW]),
      .sx  (win_size_x[w*CW +: CW]),
      .sy  (win_size_y[w*CW +: CW]),
      .hit (in_win[w])
    );
    ovl_unpack u_unp (
      .pix (win_pix[w*PIXW +: PIXW]),
      .fmt (win_fmt[w*FW +: FW]),
      .rgb (win_rgb[w])
    );
  end

  logic            key_hit, hit0_c, hit1_c;
  logic [CHW:0]    top_a;
  logic [RGBW-1:0] alpha_c;

  always_comb begin
    top_a   = pix_alpha(win_pix[TOP*PIXW +: PIXW], win_fmt[TOP*FW +: FW]);
    key_hit = in_win[TOP] && key_en &&
              (((win_rgb[TOP] ^ key_val) & key_mask) == '0);
    hit1_c  = in_win[TOP] && !key_hit;
    hit0_c  = in_win[BOT];
    if (!hit1_c)          alpha_c = '0;
    else if (top_a[CHW])  alpha_c = {3{top_a[CHW-1:0]}};
    else                  alpha_c = const_alpha;
  end

  // stage 1 registers
  logic            s1_de, s1_hit0, s1_hit1;
  logic [RGBW-1:0] s1_alpha, s1_top, s1_bot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_de    <= 1'b0;
      s1_hit0  <= 1'b0;
      s1_hit1  <= 1'b0;
      s1_alpha <= '0;
      s1_top   <= '0;
      s1_bot   <= '0;
    end else begin
      s1_de    <= pix_de;
      s1_hit0  <= hit0_c;
      s1_hit1  <= hit1_c;
      s1_alpha <= alpha_c;
      s1_top   <= win_rgb[TOP];
      s1_bot   <= hit0_c ? win_rgb[BOT] : '0;
    end
  end

  // stage 2: per-channel blend registers
  for (genvar c = 0; c < 3; c++) begin : g_ch
    ovl_blend_ch u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .de    (s1_de),
      .a     (s1_alpha[c*CHW +: CHW]),
      .t     (s1_top[c*CHW +: CHW]),
      .b     (s1_bot[c*CHW +: CHW]),
      .q     (out_rgb[c*CHW +: CHW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_de <= 1'b0;
    else        out_de <= s1_de;
  end
endmodule

// File: rtl/ovl_blend_chk.sv
module ovl_blend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_de,
  input logic        out_de,
  input logic [23:0] out_rgb,
  input logic        key_hit,
  input logic        s1_de,
  input logic        s1_hit0,
  input logic        s1_hit1,
  input logic [23:0] s1_alpha,
  input logic [23:0] s1_top,
  input logic [23:0] s1_bot
);
  assert_de_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_de |=> ##1 out_de);

  assert_de_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_de |=> ##1 !out_de);

  assert_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> out_rgb == 24'h0);

  assert_black_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_de && !s1_hit0 && !s1_hit1) |=> out_rgb == 24'h0);

  assert_opaque_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_de && s1_alpha == 24'hFFFFFF) |=> out_rgb == $past(s1_top));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_de && s1_alpha == 24'h0) |=> out_rgb == $past(s1_bot));

  assert_keyed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> !s1_hit1);
endmodule

bind ovl_blend_top ovl_blend_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_de   (pix_de),
  .out_de   (out_de),
  .out_rgb  (out_rgb),
  .key_hit  (key_hit),
  .s1_de    (s1_de),
  .s1_hit0  (s1_hit0),
  .s1_hit1  (s1_hit1),
  .s1_alpha (s1_alpha),
  .s1_top   (s1_top),
  .s1_bot   (s1_bot)
);

// File: tb/tb_ovl_blend_top.sv
module tb_ovl_blend_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] pix_x = '0, pix_y = '0;
  logic          pix_de = 1'b0;
  logic [63:0]   win_pix = '0;
  logic [1:0]    win_en = '0;
  logic [7:0]    win_fmt = '0;
  logic [2*CW-1:0] win_pos_x = '0, win_pos_y = '0, win_size_x = '0, win_size_y = '0;
  logic          key_en = 1'b0;
  logic [23:0]   key_val = 24'hFFFFFF, key_mask = 24'hFFFFFF, const_alpha = 24'hFFFFFF;
  logic          out_de;
  logic [23:0]   out_rgb;

  ovl_blend_top #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
    .win_pix(win_pix), .win_en(win_en), .win_fmt(win_fmt),
    .win_pos_x(win_pos_x), .win_pos_y(win_pos_y),
    .win_size_x(win_size_x), .win_size_y(win_size_y),
    .key_en(key_en), .key_val(key_val), .key_mask(key_mask),
    .const_alpha(const_alpha), .out_de(out_de), .out_rgb(out_rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, fails = 0;
  bit    pv = 0, done = 0;
  logic [24:0] prev_exp;
  string prev_tag;

  // returns {has_alpha, alpha, R, G, B}
  function automatic logic [32:0] ref_unpack(logic [31:0] p, int f);
    logic [7:0] b0, b1, b2, b3, r, g, b, a;
    logic [4:0] f5r, f5b;
    logic [5:0] f6;
    bit has;
    b0 = p[7:0]; b1 = p[15:8]; b2 = p[23:16]; b3 = p[31:24];
    has = (f >= 5); a = 8'h00;
    case (f)
      0, 5: begin r = b2; g = b1; b = b0; a = b3; end
      1, 6: begin r = b0; g = b1; b = b2; a = b3; end
      2, 7: begin r = b3; g = b2; b = b1; a = b0; end
      4: begin
        f5r = p[15:11]; f6 = p[10:5]; f5b = p[4:0];
        r = {f5r, 3'b000} | {5'b0, f5r[4:2]};
        g = {f6, 2'b00} | {6'b0, f6[5:4]};
        b = {f5b, 3'b000} | {5'b0, f5b[4:2]};
      end
      default: begin r = b1; g = b2; b = b3; a = b0; end
    endcase
    if (!has) a = 8'h00;
    return {has, a, r, g, b};
  endfunction

  function automatic bit ref_cover(int c, int p, int s);
    int last;
    last = (p + s == 0) ? 0 : p + s - 1;
    return (c >= p) && (c <= last);
  endfunction

  function automatic logic [24:0] model();
    logic [32:0] u0, u1;
    bit in0, in1, top;
    logic [23:0] res;
    int a, t, b;
    u0 = ref_unpack(win_pix[31:0], int'(win_fmt[3:0]));
    u1 = ref_unpack(win_pix[63:32], int'(win_fmt[7:4]));
    in0 = win_en[0] && ref_cover(int'(pix_x), int'(win_pos_x[CW-1:0]), int'(win_size_x[CW-1:0]))
                    && ref_cover(int'(pix_y), int'(win_pos_y[CW-1:0]), int'(win_size_y[CW-1:0]));
    in1 = win_en[1] && ref_cover(int'(pix_x), int'(win_pos_x[2*CW-1:CW]), int'(win_size_x[2*CW-1:CW]))
                    && ref_cover(int'(pix_y), int'(win_pos_y[2*CW-1:CW]), int'(win_size_y[2*CW-1:CW]));
    top = in1 && !(key_en && (((u1[23:0] ^ key_val) & key_mask) == 24'h0));
    for (int c = 0; c < 3; c++) begin
      t = int'(u1[c*8 +: 8]);
      b = in0 ? int'(u0[c*8 +: 8]) : 0;
      if (!top) a = 0;
      else if (u1[32]) a = int'(u1[31:24]);
      else a = int'(const_alpha[c*8 +: 8]);
      res[c*8 +: 8] = 8'((a * t + (255 - a) * b + 127) / 255);
    end
    if (!pix_de) res = 24'h0;
    return {pix_de, res};
  endfunction

  task automatic tick(string tag);
    logic [24:0] e;
    e = model();
    @(negedge clk);
    if (pv) begin
      checks++;
      if ({out_de, out_rgb} !== prev_exp) begin
        fails++;
        $display("FAIL %s got de=%0b rgb=%h expected de=%0b rgb=%h",
                 prev_tag, out_de, out_rgb, prev_exp[24], prev_exp[23:0]);
      end
    end
    prev_exp = e; prev_tag = tag; pv = 1;
  endtask

  task automatic set_win(int w, bit en, int fmt, int px, int py, int sx, int sy);
    win_en[w] = en;
    win_fmt[w*4 +: 4] = 4'(fmt);
    win_pos_x[w*CW +: CW] = CW'(px);
    win_pos_y[w*CW +: CW] = CW'(py);
    win_size_x[w*CW +: CW] = CW'(sx);
    win_size_y[w*CW +: CW] = CW'(sy);
  endtask

  task automatic at(int x, int y);
    pix_x = CW'(x); pix_y = CW'(y); pix_de = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish (R2)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (out_de !== 1'b0 || out_rgb !== 24'h0) begin
      fails++;
      $display("FAIL R1 reset got de=%0b rgb=%h expected de=0 rgb=000000", out_de, out_rgb);
    end
    rst_n = 1'b1;

    // R4: window 0 alone, each byte order
    set_win(0, 1, 0, 0, 0, 100, 100); set_win(1, 0, 0, 0, 0, 0, 0);
    at(10, 5); win_pix[31:0] = 32'hAA112233; tick("R4 xrgb");
    win_fmt[3:0] = 4'd1; win_pix[31:0] = 32'h00112233; tick("R4 xbgr");
    win_fmt[3:0] = 4'd2; win_pix[31:0] = 32'h11223344; tick("R4 rgbx");
    win_fmt[3:0] = 4'd3; tick("R4 bgrx");
    // R10: 5-6-5 widening
    win_fmt[3:0] = 4'd4; win_pix[31:0] = 32'h0000F81F; tick("R10 565 magenta");
    win_pix[31:0] = 32'hFFFF0841; tick("R10 565 low bits");
    // R5: window 1 opaque and constant-alpha blends
    win_fmt[3:0] = 4'd0; win_pix[31:0] = 32'h00204060;
    set_win(1, 1, 0, 8, 4, 4, 4); win_pix[63:32] = 32'h00C0A080;
    const_alpha = 24'hFFFFFF; at(9, 5); tick("R5 opaque replace");
    const_alpha = 24'h80FF00; tick("R5 per-channel const alpha");
    const_alpha = 24'hFFFFFF;
    // R6: per-pixel alpha, top byte and low byte
    win_fmt[7:4] = 4'd5; win_pix[63:32] = 32'h40C0A080; tick("R6 argb alpha");
    win_fmt[7:4] = 4'd7; win_pix[63:32] = 32'hC0A08040; tick("R6 rgba alpha");
    win_fmt[7:4] = 4'd12; win_pix[63:32] = 32'h80A0C0F0; tick("R6 code above 8");
    // R7: blend over black when window 0 is off
    win_en[0] = 1'b0; win_fmt[7:4] = 4'd6; win_pix[63:32] = 32'h80FF8001; tick("R7 over black");
    win_en[0] = 1'b1;
    // R3: inclusive edges of window 1 (x 8..11)
    win_fmt[7:4] = 4'd0;
    at(11, 7); tick("R3 last column and line");
    at(12, 7); tick("R3 past last column");
    at(7, 5);  tick("R3 before first column");
    at(9, 8);  tick("R3 past last line");
    // R3: clamp when start plus size is zero
    set_win(1, 1, 0, 0, 0, 0, 0);
    at(0, 0); tick("R3 clamp covers origin");
    at(1, 0); tick("R3 clamp excludes next");
    set_win(1, 1, 0, 5, 5, 0, 0);
    at(4, 4); tick("R3 empty window");
    // R8: colour key
    set_win(1, 1, 0, 8, 4, 4, 4); at(9, 5);
    key_en = 1'b1; key_val = 24'hC0A080; key_mask = 24'hFFFFFF; tick("R8 exact key match");
    key_val = 24'hC0A081; tick("R8 one bit off");
    key_mask = 24'hFFFF00; tick("R8 masked compare");
    win_en[1] = 1'b0; key_val = 24'h204060; key_mask = 24'hFFFFFF; tick("R8 window 0 never keyed");
    key_en = 1'b0;
    // R9 and R2: nothing active, then no data enable
    win_en = 2'b00; tick("R9 both disabled black");
    win_en = 2'b11; pix_de = 1'b0; tick("R2 de low zero");
    at(9, 5); tick("R2 de back");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      for (int w = 0; w < 2; w++)
        set_win(w, ($urandom_range(0, 7) != 0), $urandom_range(0, 15),
                $urandom_range(0, 30), $urandom_range(0, 30),
                $urandom_range(0, 20), $urandom_range(0, 20));
      win_pix = {$urandom(), $urandom()};
      pix_x = CW'($urandom_range(0, 45));
      pix_y = CW'($urandom_range(0, 45));
      pix_de = ($urandom_range(0, 9) != 0);
      key_en = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 1) == 1)
        key_val = ref_unpack(win_pix[63:32], int'(win_fmt[7:4]))[23:0];
      else
        key_val = 24'($urandom());
      case ($urandom_range(0, 2))
        0: key_mask = 24'h0;
        1: key_mask = 24'hFFFFFF;
        default: key_mask = 24'($urandom());
      endcase
      const_alpha = ($urandom_range(0, 1) == 1) ? 24'hFFFFFF : 24'($urandom());
      tick("R7 random mix (R3 R5 R6 R8 R9)");
    end
    pix_de = 1'b0;
    tick("R2 drain");
    tick("R2 drain");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule